// File: doc/BRIEF.md
# Beam-Dump Post-Mortem Request Gate

This block watches one beam-permit flag per ring and turns a loss of permit into a request to broadcast the post-mortem event. Each ring has its own channel. A channel holds an armed/disarmed state that decoded timing events set and clear, and a small down-counter that counts falling edges of that ring's permit flag. With the default load of one, the first fall seen while the channel is armed expires the counter and raises a request. While a channel is disarmed, falls of its flag are ignored.

The permit flags arrive asynchronously. Each one passes through a multi-stage synchroniser and a falling-edge detector that run on the system clock. Expired channels leave a pending bit in a small queue. The queue issues one send strobe per clock, together with a one-hot vector that names the ring, and serves rings in ascending index order. When both rings dump together, the event is requested twice and neither request is lost. The generator that frames and sends the event sits downstream of the strobe.

Top module: `dump_pm_gate`

## Requirements
- R1: After reset, both channels are armed, `pm_send_o` is 0 and `pm_ring_o` is all zeros.
- R2: A high-to-low change of `permit_i[k]` on an armed ring k makes `pm_send_o` go high, with `pm_ring_o` equal to the one-hot value (1 << k), in the third clock after the change. The strobe lasts exactly one clock.
- R3: A one-clock pulse on `disarm_ev_i[k]` disarms ring k. Later falls of `permit_i[k]` produce no strobe. Other rings are not affected.
- R4: A one-clock pulse on `arm_ev_i[k]` arms ring k again, and the next fall of `permit_i[k]` produces a strobe as in R2.
- R5: A low-to-high change of a permit flag never produces a strobe.
- R6: When several armed rings fall in the same clock, one strobe is issued per ring on consecutive clocks, lowest ring index first.
- R7: When `arm_ev_i[k]` and `disarm_ev_i[k]` pulse in the same clock, ring k ends up disarmed.
- R8: `pm_ring_o` has exactly one bit set while `pm_send_o` is high, and is all zeros while it is low.
- R9: A permit flag that is already low when reset is released produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| permit_i | input | N_RING | Asynchronous beam-permit flags, one per ring, high while beam is permitted |
| arm_ev_i | input | N_RING | One-clock pulse per ring: arm post-mortem generation |
| disarm_ev_i | input | N_RING | One-clock pulse per ring: disarm post-mortem generation |
| pm_send_o | output | 1 | One-clock strobe asking the generator to send the post-mortem event |
| pm_ring_o | output | N_RING | One-hot ring being served by the current strobe, all zeros when idle |

## Verification
A wrong armed/disarmed bit shows up as a missing strobe, or an unwanted one, three clocks after the next fall of that ring's flag. Until that flag falls, nothing shows at the ports. A corrupted pending bit shows on the very next clock, as a strobe that repeats, a strobe that never comes, or a ring vector that is not one-hot. A stale synchroniser stage shows as a strobe after a rising flag or after reset release. Each stimulus is therefore followed by a check of the ports on every clock up to the expected strobe and one clock past it.

// File: rtl/dump_pm_pkg.sv
package dump_pm_pkg;
  // Default geometry shared by the gate and its bench.
  localparam int unsigned DEF_RINGS   = 2;
  localparam int unsigned DEF_SYNC    = 2;
  localparam int unsigned DEF_CNT_W   = 4;
  localparam int unsigned DEF_DELAY   = 1;
endpackage

// File: rtl/pm_flag_sync.sv
module pm_flag_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_i,
  output logic fall_o
);
  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic [MSB:0] shift_q, shift_d;
  logic         last_q, last_d;

  // Stages reset low so a flag already low at release gives no edge (R9).
  always_comb begin
    shift_d = {shift_q[MSB-1:0], flag_i};
    last_d  = shift_q[MSB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      last_q  <= 1'b0;
    end else begin
      shift_q <= shift_d;
      last_q  <= last_d;
    end
  end

  assign fall_o = last_q & ~shift_q[MSB];

  // R5: an edge is reported only when the synchronised flag was high one clock earlier
  a_r5_fall_from_high: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |-> $past(shift_q[MSB]));
endmodule

// File: rtl/pm_ring_chan.sv
module pm_ring_chan #(
  parameter int unsigned CNT_W      = 4,
  parameter int unsigned FALL_DELAY = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_i,
  input  logic arm_i,
  input  logic disarm_i,
  output logic fire_o
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(FALL_DELAY);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic             armed_q, armed_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    fire_o  = 1'b0;
    if (fall_i && armed_q) begin
      if (cnt_q <= ONE) begin
        fire_o = 1'b1;
        cnt_d  = LOAD;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
    // Disarm takes precedence over arm (R7); either one reloads the count.
    if (disarm_i) begin
      armed_d = 1'b0;
      cnt_d   = LOAD;
    end else if (arm_i) begin
      armed_d = 1'b1;
      cnt_d   = LOAD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      cnt_q   <= LOAD;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  a_r7_disarm_wins: assert property (@(posedge clk) disable iff (!rst_n)
    disarm_i |=> !armed_q);
  a_r4_arm_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_i && !disarm_i) |=> armed_q);
  a_r3_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> !fire_o);
endmodule

// File: rtl/pm_send_queue.sv
module pm_send_queue #(
  parameter int unsigned N_RING = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_RING-1:0] fire_i,
  output logic              send_o,
  output logic [N_RING-1:0] ring_o
);
  logic [N_RING-1:0] pend_q, pend_d, grant;
  logic              found;

  // Lowest pending ring index is served first (R6).
  always_comb begin
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < N_RING; i++) begin
      if (pend_q[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
    pend_d = (pend_q & ~grant) | fire_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign send_o = |pend_q;
  assign ring_o = grant;

  a_r8_one_hot_send: assert property (@(posedge clk) disable iff (!rst_n)
    send_o |-> ($countones(ring_o) == 1));
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !send_o |-> (ring_o == '0));

  for (genvar g = 0; g < N_RING; g++) begin : g_pend
    a_r2_fire_held: assert property (@(posedge clk) disable iff (!rst_n)
      fire_i[g] |=> pend_q[g]);
    if (g > 0) begin : g_order
      a_r6_low_first: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q[g] && (|pend_q[g-1:0])) |-> !ring_o[g]);
    end
  end
endmodule

// File: rtl/dump_pm_gate.sv
module dump_pm_gate
  import dump_pm_pkg::*;
#(
  parameter int unsigned N_RING      = DEF_RINGS,
  parameter int unsigned SYNC_STAGES = DEF_SYNC,
  parameter int unsigned CNT_W       = DEF_CNT_W,
  parameter int unsigned FALL_DELAY  = DEF_DELAY
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_RING-1:0] permit_i,
  input  logic [N_RING-1:0] arm_ev_i,
  input  logic [N_RING-1:0] disarm_ev_i,
  output logic              pm_send_o,
  output logic [N_RING-1:0] pm_ring_o
);
  logic [N_RING-1:0] fall, fire;

  for (genvar r = 0; r < N_RING; r++) begin : g_ring
    pm_flag_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .flag_i (permit_i[r]),
      .fall_o (fall[r])
    );
    pm_ring_chan #(.CNT_W(CNT_W), .FALL_DELAY(FALL_DELAY)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .fall_i   (fall[r]),
      .arm_i    (arm_ev_i[r]),
      .disarm_i (disarm_ev_i[r]),
      .fire_o   (fire[r])
    );
  end

  pm_send_queue #(.N_RING(N_RING)) u_queue (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire_i (fire),
    .send_o (pm_send_o),
    .ring_o (pm_ring_o)
  );
endmodule

// File: tb/sim_dump_pm_gate.sv
module sim_dump_pm_gate;
  localparam int unsigned NR = 2;

  logic          clk;
  logic          rst_n;
  logic [NR-1:0] permit, arm_ev, disarm_ev;
  logic          send;
  logic [NR-1:0] ring;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  dump_pm_gate #(.N_RING(NR)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .permit_i    (permit),
    .arm_ev_i    (arm_ev),
    .disarm_ev_i (disarm_ev),
    .pm_send_o   (send),
    .pm_ring_o   (ring)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_out(input string req, input bit e_send, input logic [NR-1:0] e_ring);
    chk((send === e_send) && (ring === e_ring), req, {send, ring}, {e_send, e_ring});
  endtask

  // R8 monitor, sampled at every falling edge
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      if (send) chk($countones(ring) == 1, "R8 one-hot while sending", ring, 1);
      else      chk(ring == '0, "R8 zero while idle", ring, 0);
    end
  end

  task automatic pulse_ev(input logic [NR-1:0] a, input logic [NR-1:0] d);
    @(negedge clk);
    arm_ev = a; disarm_ev = d;
    @(negedge clk);
    arm_ev = '0; disarm_ev = '0;
  endtask

  task automatic restore_all();
    @(negedge clk);
    permit = '1;
    repeat (4) @(negedge clk);
    expect_out("R5 rising flag quiet", 1'b0, '0);
  endtask

  // Drop flags in mask; returns after the negedge where the first strobe is due.
  task automatic drop(input logic [NR-1:0] mask, input string req);
    @(negedge clk);
    permit = permit & ~mask;
    repeat (2) @(negedge clk);
    expect_out({req, " no early strobe"}, 1'b0, '0);
    @(negedge clk);
  endtask

  task automatic watch_quiet(input int cycles, input string req);
    bit seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (send) seen = 1;
    end
    chk(!seen, req, seen, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; permit = '0; arm_ev = '0; disarm_ev = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R1 reset outputs", 1'b0, '0);
    watch_quiet(6, "R9 low flag at reset release");
    restore_all();
  endtask

  task automatic t_single(input int k);
    logic [NR-1:0] m = NR'(1) << k;
    drop(m, "R2");
    expect_out("R2 strobe for ring", 1'b1, m);
    @(negedge clk);
    expect_out("R2 strobe one clock", 1'b0, '0);
    restore_all();
  endtask

  task automatic t_disarm();
    pulse_ev('0, 2'b01);
    drop(2'b11, "R3");
    expect_out("R3 only armed ring served", 1'b1, 2'b10);
    @(negedge clk);
    expect_out("R3 disarmed ring silent", 1'b0, '0);
    watch_quiet(4, "R3 no late strobe");
    restore_all();
  endtask

  task automatic t_rearm();
    pulse_ev(2'b01, '0);
    drop(2'b01, "R4");
    expect_out("R4 rearmed ring strobes", 1'b1, 2'b01);
    restore_all();
  endtask

  task automatic t_both();
    drop(2'b11, "R6");
    expect_out("R6 first ring 0", 1'b1, 2'b01);
    @(negedge clk);
    expect_out("R6 then ring 1", 1'b1, 2'b10);
    @(negedge clk);
    expect_out("R6 then idle", 1'b0, '0);
    restore_all();
  endtask

  task automatic t_clash();
    pulse_ev(2'b10, 2'b10);
    drop(2'b10, "R7");
    expect_out("R7 disarm wins", 1'b0, '0);
    watch_quiet(4, "R7 stays silent");
    restore_all();
    pulse_ev(2'b10, '0);
    drop(2'b10, "R4 after clash");
    expect_out("R4 ring 1 rearmed", 1'b1, 2'b10);
    restore_all();
  endtask

  initial begin
    t_reset();
    t_single(0);
    t_single(1);
    t_disarm();
    t_rearm();
    t_both();
    t_clash();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual %0h expected %0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule